// File: doc/BRIEF.md
# Camera Link Base Video Capture

This block sits behind an external 7:1 LVDS deserializer that delivers one 28-bit parallel word on every pixel clock. Each word holds up to 24 pixel bits, three video enables (frame, line and data) and one reserved bit. The block splits the word into these fields. It accepts a pixel only when all three nested enables are high, and only inside a frame whose frame-enable rising edge was seen after reset. Accepted pixels leave on a registered stream with valid, start-of-frame and end-of-line markers.

The end-of-line marker belongs to the last accepted pixel of a line. The block cannot know a pixel is the last one until it sees the next word, so it holds each accepted pixel for one acceptance in a single pending register. It also checks the enables for framing violations. It counts pixels per line and lines per frame, and compares each count with an expected value given on its inputs.

Top module: `cl_base_capture`

## Requirements
- R1: The input word is decoded as follows: bits [23:0] are pixel data, bit 24 is the line enable, bit 25 is the frame enable, bit 26 is the data enable and bit 27 is the reserved bit.
- R2: A pixel is accepted only when the frame, line and data enables are all high. An accepted pixel appears on `vid_data` with `vid_valid` two clock edges after the word carrying the next accepted pixel of the same line is sampled, or two edges after the word on which the line enable falls.
- R3: `vid_sof` is high together with `vid_valid` only for the first accepted pixel after a rising edge of the frame enable.
- R4: `vid_eol` is high together with `vid_valid` only for the last accepted pixel before the line enable falls.
- R5: The reserved bit has no effect on any output.
- R6: `framing_err` becomes set two edges after a word in which the line enable is high with the frame enable low, or the data enable is high with the line enable low. It then stays set until reset.
- R7: `line_len_err` pulses for one cycle, in the same cycle as the line's end-of-line output, when the accepted-pixel count of the line differs from `exp_line_pixels`.
- R8: `frame_len_err` pulses for one cycle, two edges after the word on which the frame enable falls, when the number of lines in the frame differs from `exp_frame_lines`.
- R9: A synchronous active-high `rst` clears all outputs, counters and error flags. After reset the block ignores a frame that is already in progress until the frame enable falls and rises again.
- R10: A word with the data enable low inside an active line produces no output and does not end the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| link_word | input | 28 | Parallel word from the deserializer |
| exp_line_pixels | input | CNT_W | Expected accepted pixels per line |
| exp_frame_lines | input | CNT_W | Expected lines per frame |
| vid_data | output | 24 | Pixel data of the emitted pixel |
| vid_valid | output | 1 | Emitted pixel valid |
| vid_sof | output | 1 | First pixel of a frame |
| vid_eol | output | 1 | Last pixel of a line |
| framing_err | output | 1 | Sticky enable-nesting violation |
| line_len_err | output | 1 | Line pixel count mismatch pulse |
| frame_len_err | output | 1 | Frame line count mismatch pulse |

## Verification
The bench builds the block with `CNT_W` set to 8 and expects 3 pixels per line and 2 lines per frame. These small values let short frames hit both a matching and a mismatching line length, a matching and a mismatching frame height, a single-pixel line that carries start-of-frame and end-of-line together, and a data-enable gap in the middle of a line. Directed runs cover both kinds of nesting violation, and a reset applied while a frame is already running.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int WORD_W = 28;
  localparam int PIX_W  = 24;
  localparam int LV_BIT = 24;
  localparam int FV_BIT = 25;
  localparam int DV_BIT = 26;
  localparam int SP_BIT = 27;

  typedef struct packed {
    logic             fv;
    logic             lv;
    logic             dv;
    logic [PIX_W-1:0] pix;
  } clb_fields_t;
endpackage

// File: rtl/clb_unpack.sv
module clb_unpack
  import clb_pkg::*;
(
  input  logic              clk,
  input  logic [WORD_W-1:0] word_i,
  output clb_fields_t       fld_o
);
  // Input register, datapath only; the reserved bit is dropped here (R1, R5)
  always_ff @(posedge clk) begin
    fld_o.fv  <= word_i[FV_BIT];
    fld_o.lv  <= word_i[LV_BIT];
    fld_o.dv  <= word_i[DV_BIT];
    fld_o.pix <= word_i[PIX_W-1:0];
  end
endmodule

// File: rtl/clb_qualify.sv
module clb_qualify
  import clb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  clb_fields_t      fld_i,
  output logic             acc_o,
  output logic             line_start_o,
  output logic             line_end_o,
  output logic             frame_start_o,
  output logic             frame_end_o,
  output logic [PIX_W-1:0] vid_data,
  output logic             vid_valid,
  output logic             vid_sof,
  output logic             vid_eol
);
  logic             prev_fv, in_frame, in_line;
  logic             need_sof, pend_v, pend_sof;
  logic [PIX_W-1:0] pend_data;
  logic             active, line_now;

  // A frame is active only once a rising edge was observed (R9)
  always_comb begin
    active        = fld_i.fv & (in_frame | ~prev_fv);
    line_now      = active & fld_i.lv;
    acc_o         = line_now & fld_i.dv;
    line_start_o  = line_now & ~in_line;
    line_end_o    = in_line & ~line_now;
    frame_start_o = active & ~in_frame;
    frame_end_o   = in_frame & ~active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_fv   <= 1'b1;
      in_frame  <= 1'b0;
      in_line   <= 1'b0;
      need_sof  <= 1'b0;
      pend_v    <= 1'b0;
      pend_sof  <= 1'b0;
      pend_data <= '0;
      vid_data  <= '0;
      vid_valid <= 1'b0;
      vid_sof   <= 1'b0;
      vid_eol   <= 1'b0;
    end else begin
      prev_fv   <= fld_i.fv;
      in_frame  <= active;
      in_line   <= line_now;
      vid_valid <= 1'b0;
      vid_sof   <= 1'b0;
      vid_eol   <= 1'b0;
      if (acc_o) begin
        if (pend_v) begin
          vid_valid <= 1'b1;
          vid_sof   <= pend_sof;
          vid_data  <= pend_data;
        end
        pend_v    <= 1'b1;
        pend_data <= fld_i.pix;
        pend_sof  <= need_sof | frame_start_o;
        need_sof  <= 1'b0;
      end else begin
        if (frame_start_o) need_sof <= 1'b1;
        else if (frame_end_o) need_sof <= 1'b0;
        if (line_end_o && pend_v) begin
          vid_valid <= 1'b1;
          vid_sof   <= pend_sof;
          vid_eol   <= 1'b1;
          vid_data  <= pend_data;
          pend_v    <= 1'b0;
        end
      end
    end
  end

  p_sof_valid_r3: assert property (@(posedge clk) disable iff (rst)
    vid_sof |-> vid_valid);
  p_eol_valid_r4: assert property (@(posedge clk) disable iff (rst)
    vid_eol |-> vid_valid);
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vid_valid && !vid_sof && !vid_eol));
endmodule

// File: rtl/clb_measure.sv
module clb_measure
  import clb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  clb_fields_t      fld_i,
  input  logic             acc_i,
  input  logic             line_start_i,
  input  logic             line_end_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] exp_pix_i,
  input  logic [CNT_W-1:0] exp_lines_i,
  output logic             framing_err,
  output logic             line_len_err,
  output logic             frame_len_err
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pix_cnt, line_cnt;
  logic             nest_bad;

  assign nest_bad = (fld_i.lv & ~fld_i.fv) | (fld_i.dv & ~fld_i.lv);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_cnt       <= '0;
      line_cnt      <= '0;
      framing_err   <= 1'b0;
      line_len_err  <= 1'b0;
      frame_len_err <= 1'b0;
    end else begin
      if (nest_bad) framing_err <= 1'b1;
      line_len_err  <= 1'b0;
      frame_len_err <= 1'b0;

      if (line_start_i)     pix_cnt <= acc_i ? ONE : '0;
      else if (line_end_i) begin
        pix_cnt      <= '0;
        line_len_err <= (pix_cnt != exp_pix_i);
      end else if (acc_i)   pix_cnt <= pix_cnt + ONE;

      if (frame_start_i)    line_cnt <= line_start_i ? ONE : '0;
      else if (frame_end_i) begin
        line_cnt      <= '0;
        frame_len_err <= (line_cnt != exp_lines_i);
      end else if (line_start_i) line_cnt <= line_cnt + ONE;
    end
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    framing_err |=> framing_err);
  p_lenerr_single_r7: assert property (@(posedge clk) disable iff (rst)
    line_len_err |=> !line_len_err);
  p_frmerr_single_r8: assert property (@(posedge clk) disable iff (rst)
    frame_len_err |=> !frame_len_err);
  p_err_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!framing_err && !line_len_err && !frame_len_err));
endmodule

// File: rtl/cl_base_capture.sv
module cl_base_capture
  import clb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] link_word,
  input  logic [CNT_W-1:0]  exp_line_pixels,
  input  logic [CNT_W-1:0]  exp_frame_lines,
  output logic [PIX_W-1:0]  vid_data,
  output logic              vid_valid,
  output logic              vid_sof,
  output logic              vid_eol,
  output logic              framing_err,
  output logic              line_len_err,
  output logic              frame_len_err
);
  clb_fields_t fld;
  logic acc, l_start, l_end, f_start, f_end;

  clb_unpack i_unpack (
    .clk    (clk),
    .word_i (link_word),
    .fld_o  (fld)
  );

  clb_qualify i_qualify (
    .clk           (clk),
    .rst           (rst),
    .fld_i         (fld),
    .acc_o         (acc),
    .line_start_o  (l_start),
    .line_end_o    (l_end),
    .frame_start_o (f_start),
    .frame_end_o   (f_end),
    .vid_data      (vid_data),
    .vid_valid     (vid_valid),
    .vid_sof       (vid_sof),
    .vid_eol       (vid_eol)
  );

  clb_measure #(.CNT_W(CNT_W)) i_measure (
    .clk           (clk),
    .rst           (rst),
    .fld_i         (fld),
    .acc_i         (acc),
    .line_start_i  (l_start),
    .line_end_i    (l_end),
    .frame_start_i (f_start),
    .frame_end_i   (f_end),
    .exp_pix_i     (exp_line_pixels),
    .exp_lines_i   (exp_frame_lines),
    .framing_err   (framing_err),
    .line_len_err  (line_len_err),
    .frame_len_err (frame_len_err)
  );
endmodule

// File: tb/test_cl_base_capture.sv
module test_cl_base_capture;
  localparam int CW = 8;
  localparam int NV = 18;
  // entry: f l d sp pix[7:0] | exp valid sof eol lerr ferr data[7:0]
  localparam logic [24:0] VEC [NV] = '{
    {4'b0000, 8'h00, 5'b00000, 8'h00},
    {4'b1000, 8'h00, 5'b00000, 8'h00},
    {4'b1110, 8'h11, 5'b00000, 8'h00},
    {4'b1100, 8'hEE, 5'b00000, 8'h00}, // R10 gap
    {4'b1110, 8'h12, 5'b00000, 8'h00},
    {4'b1111, 8'h13, 5'b11000, 8'h11}, // R3 sof, reserved bit set
    {4'b1000, 8'h00, 5'b10000, 8'h12},
    {4'b1000, 8'h00, 5'b10100, 8'h13}, // R4 eol, R5
    {4'b1110, 8'h21, 5'b00000, 8'h00},
    {4'b1110, 8'h22, 5'b00000, 8'h00},
    {4'b1000, 8'h00, 5'b10000, 8'h21},
    {4'b0000, 8'h00, 5'b10110, 8'h22}, // R7 short line
    {4'b0000, 8'h00, 5'b00000, 8'h00}, // R8 2 lines match
    {4'b1110, 8'h31, 5'b00000, 8'h00},
    {4'b1000, 8'h00, 5'b00000, 8'h00},
    {4'b0000, 8'h00, 5'b11110, 8'h31},
    {4'b0000, 8'h00, 5'b00001, 8'h00}, // R8 1 line mismatch
    {4'b0000, 8'h00, 5'b00000, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [27:0] word = '0;
  logic [CW-1:0] exp_px = CW'(3), exp_ln = CW'(2);
  logic [23:0] vdata;
  logic vvalid, vsof, veol, ferr_s, lerr, frerr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cl_base_capture #(.CNT_W(CW)) i_cl_base_capture (
    .clk(clk), .rst(rst), .link_word(word),
    .exp_line_pixels(exp_px), .exp_frame_lines(exp_ln),
    .vid_data(vdata), .vid_valid(vvalid), .vid_sof(vsof), .vid_eol(veol),
    .framing_err(ferr_s), .line_len_err(lerr), .frame_len_err(frerr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, leave at next negedge
  task automatic step(input bit f, input bit l, input bit d, input bit sp, input logic [7:0] p);
    word = {sp, d, f, l, 16'hA500, p};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(!vvalid && !vsof && !veol, "R9 reset outputs", vvalid, 0);
    chk(!ferr_s && !lerr && !frerr, "R9 reset errors", ferr_s, 0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      step(v[24], v[23], v[22], v[21], v[20:13]);
      chk(vvalid == v[12], "R2 valid", vvalid, v[12]);
      if (v[12]) begin
        chk(vsof == v[11], "R3 sof", vsof, v[11]);
        chk(veol == v[10], "R4 eol", veol, v[10]);
        chk(vdata == {16'hA500, v[7:0]}, "R1 R5 data", vdata, {16'hA500, v[7:0]});
      end
      chk(lerr == v[9], "R7 line length", lerr, v[9]);
      chk(frerr == v[8], "R8 frame lines", frerr, v[8]);
      chk(!ferr_s, "R6 no framing error", ferr_s, 0);
    end

    // R6: line enable without frame enable, then sticky
    step(0, 1, 0, 0, 8'h00);
    step(0, 0, 0, 0, 8'h00);
    chk(ferr_s, "R6 line outside frame", ferr_s, 1);
    step(0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 8'h00);
    chk(ferr_s, "R6 sticky", ferr_s, 1);
    do_reset();
    chk(!ferr_s, "R9 error cleared", ferr_s, 0);

    // R6: data enable without line enable
    step(1, 0, 1, 0, 8'h00);
    step(1, 0, 0, 0, 8'h00);
    chk(ferr_s, "R6 data outside line", ferr_s, 1);

    // R9: reset during a running frame; that frame is ignored
    word = {1'b0, 1'b1, 1'b1, 1'b1, 16'hA500, 8'h40};
    do_reset();
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 1, 0, 8'h41);
      chk(!vvalid, "R9 in-progress frame ignored", vvalid, 0);
    end
    step(1, 0, 0, 0, 8'h00);
    step(1, 0, 0, 0, 8'h00);
    chk(!vvalid && !lerr, "R9 no line end", vvalid, 0);
    step(0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 8'h00);
    chk(!frerr, "R9 no frame end", frerr, 0);
    step(1, 1, 1, 0, 8'h51);
    step(1, 0, 0, 0, 8'h00);
    step(1, 0, 0, 0, 8'h00);
    chk(vvalid && vsof && veol && vdata[7:0] == 8'h51, "R9 next frame captured", vdata[7:0], 8'h51);
    chk(lerr, "R7 single pixel line", lerr, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule